// File: doc/BRIEF.md
# Multicore Private Region Decoder

This block sits on the register bus of a small multicore cluster and decodes the cluster's private peripheral region, an 8 KiB span addressed by a 13-bit byte offset. A request carries an offset, write data, a write enable, a read enable and the index of the core that issued it. The block holds the cluster-level control register and a read-only configuration word itself. Every other access is forwarded to a per-core interrupt-controller CPU interface or to one of two timer slots per core. Forwarding uses a one-hot select strobe and a local register offset.

The number of cores is a parameter, from 1 to 4. It sets the configuration word and decides which forwarded accesses are real. An access whose target core index is not below the core count is dropped. Such a read returns zero, such a write raises no strobe, and the same holds whether the index came from the offset or from the requesting core. Each interface window has an alias range that targets the requesting core, and an explicit range with one 256-byte page per core.

Top module: `cluster_priv_decoder`

## Requirements
- R1: The control register at offset 0x000 resets to zero. A write there stores all data bits, and a later read returns the stored value. No other access changes it.
- R2: Offset 0x004 reads a configuration word. Bits [7:4] carry a mask with one set bit per present core, ((1<<NUM_CORES)-1). Bits [1:0] carry NUM_CORES-1, and all other bits are zero. Writes to this offset have no effect.
- R3: Offset 0x008 and every other offset below 0x100 except 0x000 and 0x004 read as zero.
- R4: Offsets 0x100–0x1FF target the CPU interface of the requesting core. The strobe bit `cif_sel[core]` is raised and `cif_off` is offset bits [7:0].
- R5: Offsets 0x200–0x5FF target the CPU interface of core (offset-0x200)>>8, with `cif_off` equal to offset bits [7:0].
- R6: Offsets 0x600–0x6FF target the timers of the requesting core. Slot core*2+offset[5] is strobed on `tmr_sel`, and `tmr_off` is offset bits [3:0].
- R7: Offsets 0x700–0xAFF target the timers of core (offset-0x700)>>8. The slot and local offset follow the same rule as in R6.
- R8: When the target core index is NUM_CORES or above, no strobe is raised and `per_we` stays low. A read of such a core returns zero.
- R9: Offsets 0xB00 and above read as zero, raise no strobe and change no state.
- R10: Strobes, `per_we`, `per_wdata` and the local offsets appear in the cycle after the request and last one cycle. At most one strobe bit is high at a time. `bus_rdata` carries read data in the cycle after `bus_re` and is zero in any cycle that does not follow a read.
- R11: For a forwarded read, `bus_rdata` returns the word that the selected interface or timer slot presents on its read-data input while its strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_off | input | 13 | Byte offset within the region |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write request |
| bus_re | input | 1 | Read request |
| bus_core | input | 2 | Index of the requesting core |
| bus_rdata | output | DATA_W | Read data, one cycle after `bus_re` |
| cif_sel | output | NUM_CORES | One-hot CPU interface select strobe |
| cif_off | output | 8 | Local CPU interface register offset |
| tmr_sel | output | 2*NUM_CORES | One-hot timer slot select strobe |
| tmr_off | output | 4 | Local timer register offset |
| per_we | output | 1 | Forwarded access is a write |
| per_wdata | output | DATA_W | Forwarded write data |
| cif_rdata | input | NUM_CORES*DATA_W | Read data from each CPU interface, core 0 in the low word |
| tmr_rdata | input | 2*NUM_CORES*DATA_W | Read data from each timer slot, slot 0 in the low word |

## Verification
Every decoded route lives for exactly one cycle. A wrong routing state therefore shows one cycle after the request, as a wrong or extra strobe bit, a wrong local offset, or read data taken from the wrong source. A corrupted control register persists and stays hidden until the next read of offset 0x000. For that reason the bench reads it back after each kind of access that could have touched it. Suppression of absent cores is observed directly: the cycle after such a request must show all strobes low and zero read data.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    localparam int MAX_CORES = 4;
    localparam int CORE_W    = 2;
    localparam int OFF_W     = 13;
    localparam int LOC_W     = 8;
    localparam int TOFF_W    = 4;
    localparam int SLOT_W    = CORE_W + 1;

    localparam logic [OFF_W-1:0] CIF_ALIAS  = 13'h100;
    localparam logic [OFF_W-1:0] CIF_BASE   = 13'h200;
    localparam logic [OFF_W-1:0] TMR_ALIAS  = 13'h600;
    localparam logic [OFF_W-1:0] TMR_BASE   = 13'h700;
    localparam logic [OFF_W-1:0] REGION_END = 13'hB00;

    localparam logic [LOC_W-1:0] CTRL_OFF = 8'h00;
    localparam logic [LOC_W-1:0] CFG_OFF  = 8'h04;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_SCU,
        WIN_CIF,
        WIN_TMR
    } win_e;

    typedef enum logic [1:0] {
        RD_ZERO,
        RD_SCU,
        RD_CIF,
        RD_TMR
    } rsrc_e;

    typedef struct packed {
        win_e              win;
        logic [CORE_W-1:0] core;
        logic              present;
    } route_t;

endpackage

// File: rtl/cpd_addr_decode.sv
module cpd_addr_decode
    import cpd_pkg::*;
#(
    parameter int NUM_CORES = 1
) (
    input  logic [OFF_W-1:0]  offset,
    input  logic [CORE_W-1:0] req_core,
    output route_t            route
);

    always_comb begin
        route = '0;
        if (offset < CIF_ALIAS) begin
            route.win  = WIN_SCU;
            route.core = '0;
        end else if (offset < CIF_BASE) begin
            route.win  = WIN_CIF;
            route.core = req_core;
        end else if (offset < TMR_ALIAS) begin
            route.win  = WIN_CIF;
            route.core = CORE_W'(offset[10:8] - 3'd2);
        end else if (offset < TMR_BASE) begin
            route.win  = WIN_TMR;
            route.core = req_core;
        end else if (offset < REGION_END) begin
            route.win  = WIN_TMR;
            route.core = CORE_W'(offset[11:8] - 4'd7);
        end else begin
            route.win  = WIN_NONE;
            route.core = '0;
        end

        if (route.win == WIN_SCU) begin
            route.present = 1'b1;
        end else if (route.win == WIN_NONE) begin
            route.present = 1'b0;
        end else begin
            route.present = (int'(route.core) < NUM_CORES);
        end
    end

endmodule

// File: rtl/cpd_scu_regs.sv
module cpd_scu_regs
    import cpd_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int DATA_W    = 32
) (
    input  logic [LOC_W-1:0]  reg_off,
    input  logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] rd_val
);

    localparam logic [3:0] CORE_MASK = 4'((1 << NUM_CORES) - 1);
    localparam logic [1:0] COUNT_M1  = 2'(NUM_CORES - 1);
    localparam logic [DATA_W-1:0] CFG_WORD =
        DATA_W'({CORE_MASK, 2'b00, COUNT_M1});

    always_comb begin
        case (reg_off)
            CTRL_OFF: rd_val = ctrl_q;
            CFG_OFF:  rd_val = CFG_WORD;
            default:  rd_val = '0;
        endcase
    end

endmodule

// File: rtl/cpd_rdata_mux.sv
module cpd_rdata_mux
    import cpd_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int DATA_W    = 32
) (
    input  rsrc_e                           src,
    input  logic [SLOT_W-1:0]               idx,
    input  logic [DATA_W-1:0]               scu_val,
    input  logic [NUM_CORES*DATA_W-1:0]     cif_rdata,
    input  logic [2*NUM_CORES*DATA_W-1:0]   tmr_rdata,
    output logic [DATA_W-1:0]               rdata
);

    localparam int N_SLOTS = 2 * NUM_CORES;

    logic [DATA_W-1:0] cif_word [NUM_CORES];
    logic [DATA_W-1:0] tmr_word [N_SLOTS];

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_cif
        assign cif_word[g] = cif_rdata[g*DATA_W +: DATA_W];
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_tmr
        assign tmr_word[g] = tmr_rdata[g*DATA_W +: DATA_W];
    end

    always_comb begin
        rdata = '0;
        case (src)
            RD_SCU: rdata = scu_val;
            RD_CIF: begin
                for (int i = 0; i < NUM_CORES; i++) begin
                    if (int'(idx) == i) rdata = cif_word[i];
                end
            end
            RD_TMR: begin
                for (int i = 0; i < N_SLOTS; i++) begin
                    if (int'(idx) == i) rdata = tmr_word[i];
                end
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/cluster_priv_decoder.sv
module cluster_priv_decoder
    import cpd_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int DATA_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [OFF_W-1:0]                 bus_off,
    input  logic [DATA_W-1:0]                bus_wdata,
    input  logic                             bus_we,
    input  logic                             bus_re,
    input  logic [CORE_W-1:0]                bus_core,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic [NUM_CORES-1:0]             cif_sel,
    output logic [LOC_W-1:0]                 cif_off,
    output logic [2*NUM_CORES-1:0]           tmr_sel,
    output logic [TOFF_W-1:0]                tmr_off,
    output logic                             per_we,
    output logic [DATA_W-1:0]                per_wdata,
    input  logic [NUM_CORES*DATA_W-1:0]      cif_rdata,
    input  logic [2*NUM_CORES*DATA_W-1:0]    tmr_rdata
);

    localparam int N_SLOTS = 2 * NUM_CORES;

    typedef struct packed {
        logic [DATA_W-1:0]    ctrl;
        logic [DATA_W-1:0]    scu_rd;
        logic [DATA_W-1:0]    wdata;
        logic [NUM_CORES-1:0] cif_sel;
        logic [N_SLOTS-1:0]   tmr_sel;
        logic                 we;
        logic [LOC_W-1:0]     loc_off;
        logic [TOFF_W-1:0]    tmr_off;
        rsrc_e                rsrc;
        logic [SLOT_W-1:0]    ridx;
    } state_t;

    state_t            st_d, st_q;
    route_t            route;
    logic [DATA_W-1:0] scu_val;
    logic [SLOT_W-1:0] slot;
    logic              access;

    cpd_addr_decode #(
        .NUM_CORES (NUM_CORES)
    ) u_decode (
        .offset   (bus_off),
        .req_core (bus_core),
        .route    (route)
    );

    cpd_scu_regs #(
        .NUM_CORES (NUM_CORES),
        .DATA_W    (DATA_W)
    ) u_scu (
        .reg_off (bus_off[LOC_W-1:0]),
        .ctrl_q  (st_q.ctrl),
        .rd_val  (scu_val)
    );

    cpd_rdata_mux #(
        .NUM_CORES (NUM_CORES),
        .DATA_W    (DATA_W)
    ) u_rmux (
        .src       (st_q.rsrc),
        .idx       (st_q.ridx),
        .scu_val   (st_q.scu_rd),
        .cif_rdata (cif_rdata),
        .tmr_rdata (tmr_rdata),
        .rdata     (bus_rdata)
    );

    assign access = bus_we | bus_re;
    assign slot   = {route.core, bus_off[5]};

    always_comb begin
        st_d         = st_q;
        st_d.cif_sel = '0;
        st_d.tmr_sel = '0;
        st_d.we      = 1'b0;
        st_d.rsrc    = RD_ZERO;

        if (access) begin
            case (route.win)
                WIN_SCU: begin
                    if (bus_re) begin
                        st_d.rsrc   = RD_SCU;
                        st_d.scu_rd = scu_val;
                    end
                    if (bus_we && (bus_off[LOC_W-1:0] == CTRL_OFF)) begin
                        st_d.ctrl = bus_wdata;
                    end
                end
                WIN_CIF: begin
                    if (route.present) begin
                        for (int i = 0; i < NUM_CORES; i++) begin
                            if (int'(route.core) == i) st_d.cif_sel[i] = 1'b1;
                        end
                        st_d.loc_off = bus_off[LOC_W-1:0];
                        st_d.we      = bus_we;
                        if (bus_we) st_d.wdata = bus_wdata;
                        if (bus_re) begin
                            st_d.rsrc = RD_CIF;
                            st_d.ridx = {1'b0, route.core};
                        end
                    end
                end
                WIN_TMR: begin
                    if (route.present) begin
                        for (int i = 0; i < N_SLOTS; i++) begin
                            if (int'(slot) == i) st_d.tmr_sel[i] = 1'b1;
                        end
                        st_d.tmr_off = bus_off[TOFF_W-1:0];
                        st_d.we      = bus_we;
                        if (bus_we) st_d.wdata = bus_wdata;
                        if (bus_re) begin
                            st_d.rsrc = RD_TMR;
                            st_d.ridx = slot;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cif_sel   = st_q.cif_sel;
    assign cif_off   = st_q.loc_off;
    assign tmr_sel   = st_q.tmr_sel;
    assign tmr_off   = st_q.tmr_off;
    assign per_we    = st_q.we;
    assign per_wdata = st_q.wdata;

    // R10
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cif_sel, tmr_sel}));

    // R10
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{cif_sel, tmr_sel}) |-> $past(bus_we | bus_re));

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0));

    // R8
    absent_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && (route.win inside {WIN_CIF, WIN_TMR}) && !route.present)
        |=> (cif_sel == '0 && tmr_sel == '0 && !per_we && bus_rdata == '0));

    // R9
    out_of_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && bus_off >= REGION_END)
        |=> (cif_sel == '0 && tmr_sel == '0 && !per_we && bus_rdata == '0));

    // R1
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_off == 13'h000) |=> $stable(st_q.ctrl));

endmodule

// File: tb/cluster_priv_decoder_tb.sv
module cluster_priv_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 3;
    localparam int DW         = 32;
    localparam int NS         = 2 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [12:0]   bus_off = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [1:0]    bus_core = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  cif_sel;
    logic [7:0]    cif_off;
    logic [NS-1:0] tmr_sel;
    logic [3:0]    tmr_off;
    logic          per_we;
    logic [DW-1:0] per_wdata;
    logic [N*DW-1:0]  cif_rdata;
    logic [NS*DW-1:0] tmr_rdata;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] ctrl_model = '0;

    typedef struct {
        logic [N-1:0]  cif;
        logic [NS-1:0] tmr;
        logic          we;
        logic [7:0]    off;
        logic [3:0]    toff;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rd;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cluster_priv_decoder #(
        .NUM_CORES (N),
        .DATA_W    (DW)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_off   (bus_off),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_core  (bus_core),
        .bus_rdata (bus_rdata),
        .cif_sel   (cif_sel),
        .cif_off   (cif_off),
        .tmr_sel   (tmr_sel),
        .tmr_off   (tmr_off),
        .per_we    (per_we),
        .per_wdata (per_wdata),
        .cif_rdata (cif_rdata),
        .tmr_rdata (tmr_rdata)
    );

    // Peripheral stubs: each word encodes its own index and the local offset.
    always_comb begin
        for (int c = 0; c < N; c++)
            cif_rdata[c*DW +: DW] = {16'hC1F0, 8'(c), cif_off};
        for (int s = 0; s < NS; s++)
            tmr_rdata[s*DW +: DW] = {16'hD7E0, 8'(s), 4'h0, tmr_off};
    end

    function automatic logic [DW-1:0] cif_word(int c, logic [7:0] off);
        return {16'hC1F0, 8'(c), off};
    endfunction

    function automatic logic [DW-1:0] tmr_word(int s, logic [3:0] off);
        return {16'hD7E0, 8'(s), 4'h0, off};
    endfunction

    task automatic check_val(input string tag, input logic [DW-1:0] act,
                             input logic [DW-1:0] expv, input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Driver: applies one request and queues the expected result.
    task automatic access(input logic we, input logic re, input logic [12:0] a,
                          input logic [1:0] c, input logic [DW-1:0] wd,
                          input string tag);
        exp_t e;
        int   tgt;
        @(negedge clk);
        bus_we = we; bus_re = re; bus_off = a; bus_core = c; bus_wdata = wd;
        e.cif = '0; e.tmr = '0; e.we = 1'b0; e.off = '0; e.toff = '0;
        e.wdata = '0; e.rd = '0; e.tag = tag;
        if (we || re) begin
            if (a < 13'h100) begin
                if (re) begin
                    if (a == 13'h000) e.rd = ctrl_model;
                    else if (a == 13'h004)
                        e.rd = 32'(((1 << N) - 1) << 4) | 32'(N - 1);
                end
                if (we && a == 13'h000) ctrl_model = wd;
            end else if (a < 13'h600) begin
                tgt = (a < 13'h200) ? int'(c) : (int'(a) - 'h200) >> 8;
                if (tgt < N) begin
                    e.cif[tgt] = 1'b1;
                    e.off = a[7:0];
                    e.we = we;
                    e.wdata = wd;
                    if (re) e.rd = cif_word(tgt, a[7:0]);
                end
            end else if (a < 13'h B00) begin
                tgt = (a < 13'h700) ? int'(c) : (int'(a) - 'h700) >> 8;
                if (tgt < N) begin
                    e.tmr[tgt*2 + int'(a[5])] = 1'b1;
                    e.toff = a[3:0];
                    e.we = we;
                    e.wdata = wd;
                    if (re) e.rd = tmr_word(tgt*2 + int'(a[5]), a[3:0]);
                end
            end
        end
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        access(1'b0, 1'b0, 13'h000, 2'd0, '0, tag);
    endtask

    // Monitor: compares the cycle after each request.
    always begin
        exp_t e;
        @(posedge clk);
        #1;
        if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            check_val(e.tag, DW'(cif_sel), DW'(e.cif), "cif_sel");
            check_val(e.tag, DW'(tmr_sel), DW'(e.tmr), "tmr_sel");
            check_val(e.tag, DW'(per_we), DW'(e.we), "per_we");
            check_val(e.tag, bus_rdata, e.rd, "rdata");
            if (e.cif != '0) check_val(e.tag, DW'(cif_off), DW'(e.off), "cif_off");
            if (e.tmr != '0) check_val(e.tag, DW'(tmr_off), DW'(e.toff), "tmr_off");
            if (e.we) check_val(e.tag, per_wdata, e.wdata, "per_wdata");
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset value, R10 idle outputs after reset
        idle("R10_reset_idle");
        access(0, 1, 13'h000, 0, '0, "R1_reset_ctrl");
        // R2 configuration word
        access(0, 1, 13'h004, 1, '0, "R2_cfg");
        // R3 status and unused SCU offsets
        access(0, 1, 13'h008, 0, '0, "R3_status");
        access(0, 1, 13'h0FC, 2, '0, "R3_unused");
        // R1 write then read back
        access(1, 0, 13'h000, 0, 32'h1234_5678, "R1_write");
        access(0, 1, 13'h000, 0, '0, "R1_readback");
        // R2 write to config ignored
        access(1, 0, 13'h004, 0, 32'hFFFF_FFFF, "R2_write_ignored");
        access(0, 1, 13'h004, 0, '0, "R2_cfg_after_write");
        // R4 alias of requesting core
        access(0, 1, 13'h1A4, 1, '0, "R4_alias_read");
        access(1, 0, 13'h110, 2, 32'hCAFE_0001, "R4_alias_write");
        idle("R10_gap");
        // R5 explicit core pages, R11 read return
        access(0, 1, 13'h308, 0, '0, "R5_core1_read");
        access(1, 0, 13'h4FC, 3, 32'hCAFE_0002, "R5_core2_write");
        access(0, 1, 13'h2C0, 2, '0, "R11_core0_read");
        // R8 absent core via page and via requester
        access(0, 1, 13'h510, 0, '0, "R8_page_read");
        access(1, 0, 13'h520, 0, 32'hDEAD_0001, "R8_page_write");
        access(0, 1, 13'h100, 3, '0, "R8_req_alias_read");
        access(1, 0, 13'h640, 3, 32'hDEAD_0002, "R8_req_timer_write");
        // R6 timer alias
        access(0, 1, 13'h62C, 2, '0, "R6_alias_read");
        access(1, 0, 13'h604, 0, 32'hBEEF_0001, "R6_alias_write");
        // R7 timer explicit pages
        access(0, 1, 13'h828, 1, '0, "R7_core1_slot3");
        access(1, 0, 13'h90C, 0, 32'hBEEF_0002, "R7_core2_slot4");
        access(0, 1, 13'h73F, 2, '0, "R7_core0_slot1");
        access(0, 1, 13'hA20, 0, '0, "R8_timer_page3");
        // R9 outside region
        access(0, 1, 13'hB00, 0, '0, "R9_read");
        access(1, 0, 13'hC00, 0, 32'h0BAD_0BAD, "R9_write");
        access(1, 1, 13'h1FFF, 1, 32'h0BAD_0BAD, "R9_top");
        access(0, 1, 13'h000, 0, '0, "R1_R9_ctrl_unchanged");
        // R10 back-to-back and single-cycle strobes
        access(0, 1, 13'h3FF, 1, '0, "R10_b2b_a");
        access(0, 1, 13'h6E0, 1, '0, "R10_b2b_b");
        idle("R10_after");
        access(1, 0, 13'h000, 0, 32'h0000_00A5, "R1_write2");
        access(0, 1, 13'h000, 0, '0, "R1_readback2");
        idle("R10_tail");
        idle("R10_tail2");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule